// File: doc/BRIEF.md
# Command/Data Event Status and Interrupt Unit

This unit collects completion and error event pulses for a memory-card host controller and turns them into two active-high interrupt lines. There are two separate groups. The command group covers command transactions and the data group covers data transactions. Each event pulse sets a sticky status bit. Each bit has its own enable bit, and the interrupt line of a group is the registered OR of the status bits that are both set and enabled. The command group also keeps a summary error bit, which is set whenever any individual command error arrives.

Software reaches four registers through a plain register port with a two-bit address. Writes take effect at the clock edge, and reads are combinational. Status bits stay readable whatever the enable settings are, so a driver can poll without using interrupts. The unit does no error detection of its own. Timeout, CRC and FIFO problems arrive as single-cycle input pulses.

Top module: `evt_irq_unit`

## Requirements
- R1: After reset, all status bits, all enable bits and both interrupt outputs are 0, so every event is masked.
- R2: The command status register at address 0 records pulses sticky: bit 0 completion, bit 2 timeout, bit 3 response CRC mismatch, bit 4 wrong response index. A set bit stays set until software clears it.
- R3: Command status bit 1 (error summary) is set in the cycle after any timeout, CRC or index pulse. A completion pulse alone leaves it clear.
- R4: The data status register at address 2 records pulses sticky: bit 0 completion, bit 1 data CRC mismatch, bit 2 internal FIFO error.
- R5: Writing a status register clears each bit whose written value is 0 and keeps each bit whose written value is 1. A write never sets a status bit.
- R6: When an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R7: Each interrupt output is a register that equals the OR of (status AND enable) of its group from the previous cycle. It therefore rises one cycle after an enabled bit sets, and falls one cycle after the last enabled set bit is cleared or disabled.
- R8: A status bit whose enable is 0 is still recorded and readable, but it never raises the interrupt.
- R9: The enable registers are at address 1 (command, 5 bits) and address 3 (data, 3 bits). They read back the written low bits, and the upper read bits are 0.
- R10: Events and writes for one group never change the status of the other group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select (0 cmd status, 1 cmd enable, 2 data status, 3 data enable) |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Combinational read data of the selected register |
| cmd_done_p | input | 1 | Command completed pulse |
| cmd_timeout_p | input | 1 | Command response timeout pulse |
| cmd_crc_p | input | 1 | Command response CRC mismatch pulse |
| cmd_index_p | input | 1 | Command response index mismatch pulse |
| dat_done_p | input | 1 | Data transfer completed pulse |
| dat_crc_p | input | 1 | Data CRC mismatch pulse |
| dat_fifo_p | input | 1 | Data FIFO underrun/overrun pulse |
| irq_cmd | output | 1 | Command group interrupt, active high |
| irq_dat | output | 1 | Data group interrupt, active high |

## Verification
The embedded assertions check several properties on every cycle:
- any event sets its bit by the next cycle, including against a same-cycle clear;
- no write ever creates a status bit;
- set bits survive cycles without a write;
- each interrupt register follows the previous cycle's enabled status;
- a group with all enables cleared stays quiet;
- the error summary follows any command error;
- the data group is unaffected by command activity.

Only the bench scenarios can show the following:
- the register address map and the bit positions of each event;
- the read-back of enables with zeroed upper bits;
- the reset values;
- that completion alone leaves the summary clear.

The bench shows these by sweeping every combination of event pulses against varied enable patterns.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int CMD_W = 5;
  localparam int DAT_W = 3;

  localparam int CB_DONE = 0;
  localparam int CB_ERR  = 1;
  localparam int CB_TMO  = 2;
  localparam int CB_CRC  = 3;
  localparam int CB_IDX  = 4;

  localparam int DB_DONE = 0;
  localparam int DB_CRC  = 1;
  localparam int DB_FIFO = 2;

  typedef enum logic [1:0] {
    RA_CMD_STAT = 2'd0,
    RA_CMD_EN   = 2'd1,
    RA_DAT_STAT = 2'd2,
    RA_DAT_EN   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic         clr_we,
  input  logic [W-1:0] keep,
  output logic [W-1:0] stat
);
  logic [W-1:0] kept;

  always_comb begin
    kept = clr_we ? (stat & keep) : stat;
  end

  always_ff @(posedge clk) begin
    if (rst) stat <= '0;
    else     stat <= kept | evt;
  end

  // R6: an event wins over a clear in the same cycle
  a_r6_event_sets: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((stat & $past(evt)) == $past(evt)));

  // R5: a write can only clear bits, never create them
  a_r5_no_write_set: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat & ~$past(stat) & ~$past(evt)) == '0));

  // R2: set bits survive cycles without a clearing write
  a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
    !clr_we |=> ((stat & $past(stat)) == $past(stat)));
endmodule

// File: rtl/evt_irq_line.sv
module evt_irq_line #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] stat,
  input  logic         en_we,
  input  logic [W-1:0] en_wdata,
  output logic [W-1:0] en,
  output logic         irq
);
  logic [W-1:0] live;

  always_comb begin
    live = stat & en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en  <= '0;
      irq <= 1'b0;
    end else begin
      if (en_we) en <= en_wdata;
      irq <= |live;
    end
  end

  // R7: interrupt follows the previous cycle's enabled status
  a_r7_irq_tracks: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == |($past(stat) & $past(en))));

  // R8: a fully masked group keeps its line low
  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (en == '0) |=> !irq);
endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit
  import evt_irq_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       reg_addr,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             cmd_done_p,
  input  logic             cmd_timeout_p,
  input  logic             cmd_crc_p,
  input  logic             cmd_index_p,
  input  logic             dat_done_p,
  input  logic             dat_crc_p,
  input  logic             dat_fifo_p,
  output logic             irq_cmd,
  output logic             irq_dat
);
  localparam int CPAD = REG_W - CMD_W;
  localparam int DPAD = REG_W - DAT_W;

  reg_addr_e    sel;
  logic [CMD_W-1:0] cmd_evt, cmd_stat, cmd_en;
  logic [DAT_W-1:0] dat_evt, dat_stat, dat_en;
  logic cmd_any_err;
  logic we_cst, we_cen, we_dst, we_den;
  logic unused_hi;

  assign sel       = reg_addr_e'(reg_addr);
  assign unused_hi = ^reg_wdata[REG_W-1:CMD_W];

  always_comb begin
    cmd_any_err      = cmd_timeout_p | cmd_crc_p | cmd_index_p;
    cmd_evt          = '0;
    cmd_evt[CB_DONE] = cmd_done_p;
    cmd_evt[CB_ERR]  = cmd_any_err;
    cmd_evt[CB_TMO]  = cmd_timeout_p;
    cmd_evt[CB_CRC]  = cmd_crc_p;
    cmd_evt[CB_IDX]  = cmd_index_p;
    dat_evt          = '0;
    dat_evt[DB_DONE] = dat_done_p;
    dat_evt[DB_CRC]  = dat_crc_p;
    dat_evt[DB_FIFO] = dat_fifo_p;
  end

  always_comb begin
    we_cst = reg_we && (sel == RA_CMD_STAT);
    we_cen = reg_we && (sel == RA_CMD_EN);
    we_dst = reg_we && (sel == RA_DAT_STAT);
    we_den = reg_we && (sel == RA_DAT_EN);
  end

  evt_status_bank #(.W(CMD_W)) u_cmd_stat (
    .clk(clk), .rst(rst), .evt(cmd_evt), .clr_we(we_cst),
    .keep(reg_wdata[CMD_W-1:0]), .stat(cmd_stat)
  );

  evt_status_bank #(.W(DAT_W)) u_dat_stat (
    .clk(clk), .rst(rst), .evt(dat_evt), .clr_we(we_dst),
    .keep(reg_wdata[DAT_W-1:0]), .stat(dat_stat)
  );

  evt_irq_line #(.W(CMD_W)) u_cmd_irq (
    .clk(clk), .rst(rst), .stat(cmd_stat), .en_we(we_cen),
    .en_wdata(reg_wdata[CMD_W-1:0]), .en(cmd_en), .irq(irq_cmd)
  );

  evt_irq_line #(.W(DAT_W)) u_dat_irq (
    .clk(clk), .rst(rst), .stat(dat_stat), .en_we(we_den),
    .en_wdata(reg_wdata[DAT_W-1:0]), .en(dat_en), .irq(irq_dat)
  );

  always_comb begin
    unique case (sel)
      RA_CMD_STAT: reg_rdata = {{CPAD{1'b0}}, cmd_stat};
      RA_CMD_EN:   reg_rdata = {{CPAD{1'b0}}, cmd_en};
      RA_DAT_STAT: reg_rdata = {{DPAD{1'b0}}, dat_stat};
      default:     reg_rdata = {{DPAD{1'b0}}, dat_en};
    endcase
  end

  // R3: any individual command error raises the summary bit
  a_r3_err_summary: assert property (@(posedge clk) disable iff (rst)
    (cmd_timeout_p | cmd_crc_p | cmd_index_p) |=> cmd_stat[CB_ERR]);

  // R10: command activity leaves the data group untouched
  a_r10_dat_isolated: assert property (@(posedge clk) disable iff (rst)
    (!dat_done_p && !dat_crc_p && !dat_fifo_p && !we_dst) |=> $stable(dat_stat));
endmodule

// File: tb/evt_irq_unit_test.sv
module evt_irq_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic c_done = 0, c_tmo = 0, c_crc = 0, c_idx = 0;
  logic d_done = 0, d_crc = 0, d_fifo = 0;
  logic irq_cmd, irq_dat;

  int checks = 0;
  int errors = 0;

  logic [4:0] m_cst, m_cen;
  logic [2:0] m_dst, m_den;
  logic       m_icmd, m_idat;

  always #10 clk = ~clk;

  evt_irq_unit uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmd_done_p(c_done), .cmd_timeout_p(c_tmo), .cmd_crc_p(c_crc),
    .cmd_index_p(c_idx), .dat_done_p(d_done), .dat_crc_p(d_crc),
    .dat_fifo_p(d_fifo), .irq_cmd(irq_cmd), .irq_dat(irq_dat)
  );

  // Reference model written from the requirements
  always @(posedge clk) begin
    if (rst) begin
      m_cst <= 0; m_cen <= 0; m_dst <= 0; m_den <= 0; m_icmd <= 0; m_idat <= 0;
    end else begin
      m_icmd <= |(m_cst & m_cen);
      m_idat <= |(m_dst & m_den);
      m_cst  <= ((reg_we && reg_addr == 0) ? (m_cst & reg_wdata[4:0]) : m_cst)
                | {c_idx, c_crc, c_tmo, (c_tmo | c_crc | c_idx), c_done};
      m_dst  <= ((reg_we && reg_addr == 2) ? (m_dst & reg_wdata[2:0]) : m_dst)
                | {d_fifo, d_crc, d_done};
      if (reg_we && reg_addr == 1) m_cen <= reg_wdata[4:0];
      if (reg_we && reg_addr == 3) m_den <= reg_wdata[2:0];
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  // Called just after a negedge with reg_we low
  task automatic check_all();
    logic [7:0] v;
    rd(2'd0, v); chk("R2", v, {3'b0, m_cst});
    rd(2'd1, v); chk("R9", v, {3'b0, m_cen});
    rd(2'd2, v); chk("R4", v, {5'b0, m_dst});
    rd(2'd3, v); chk("R9", v, {5'b0, m_den});
    chk("R7", {7'b0, irq_cmd}, {7'b0, m_icmd});
    chk("R7", {7'b0, irq_dat}, {7'b0, m_idat});
  endtask

  task automatic drive(input logic we, input logic [1:0] a, input logic [7:0] d,
                       input logic [6:0] ev);
    reg_we = we; reg_addr = a; reg_wdata = d;
    {d_fifo, d_crc, d_done, c_idx, c_crc, c_tmo, c_done} = ev;
    @(negedge clk);
    reg_we = 0;
    {d_fifo, d_crc, d_done, c_idx, c_crc, c_tmo, c_done} = 7'd0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R1: reset values
    rst = 0;
    check_all();
    rd(2'd0, v); chk("R1", v, 8'h00);
    rd(2'd1, v); chk("R1", v, 8'h00);
    chk("R1", {6'b0, irq_cmd, irq_dat}, 8'h00);

    // R9: enable read-back with upper bits zero
    drive(1, 2'd1, 8'hFF, 0); rd(2'd1, v); chk("R9", v, 8'h1F);
    drive(1, 2'd3, 8'hFF, 0); rd(2'd3, v); chk("R9", v, 8'h07);
    drive(1, 2'd1, 8'h00, 0); drive(1, 2'd3, 8'h00, 0); check_all();

    // Sweep of every event combination against varied enables
    for (int p = 0; p < 128; p++) begin
      drive(1, 2'd1, 8'((p * 11) & 31), 0); check_all();
      drive(1, 2'd3, 8'((p * 5) & 7), 7'(p)); check_all();
      drive(0, 2'd0, 8'd0, 0); check_all();
      drive(1, 2'd0, 8'((p * 3) & 31), 0); check_all();
      drive(1, 2'd0, 8'd0, 0); check_all();
      drive(1, 2'd2, 8'd0, 0); check_all();
      drive(0, 2'd0, 8'd0, 0); check_all();
    end

    // R3 and R8: CRC error alone with all enables off
    drive(1, 2'd1, 8'd0, 0); drive(1, 2'd3, 8'd0, 0);
    drive(0, 2'd0, 8'd0, 7'b0000100);
    rd(2'd0, v); chk("R3", v, 8'h0A);
    drive(0, 2'd0, 8'd0, 0);
    chk("R8", {7'b0, irq_cmd}, 8'h00);
    drive(1, 2'd0, 8'd0, 0);
    // R3: completion alone leaves the summary clear
    drive(0, 2'd0, 8'd0, 7'b0000001);
    rd(2'd0, v); chk("R3", v, 8'h01);
    // R10: a data event does not touch the command group, and vice versa
    drive(0, 2'd0, 8'd0, 7'b1000000);
    rd(2'd0, v); chk("R10", v, 8'h01);
    rd(2'd2, v); chk("R10", v, 8'h04);
    drive(1, 2'd0, 8'h00, 0);
    rd(2'd2, v); chk("R10", v, 8'h04);
    drive(0, 2'd0, 8'd0, 7'b0000001);
    // R5: selective clear, no set by write
    drive(1, 2'd0, 8'hFE, 0);
    rd(2'd0, v); chk("R5", v, 8'h00);
    drive(1, 2'd0, 8'hFF, 0);
    rd(2'd0, v); chk("R5", v, 8'h00);
    drive(1, 2'd2, 8'hFF, 0);
    rd(2'd2, v); chk("R5", v, 8'h04);
    // R6: event and clear in the same cycle
    drive(1, 2'd2, 8'h00, 7'b0100000);
    rd(2'd2, v); chk("R6", v, 8'h02);
    // R7: rise one cycle after enable, fall one cycle after clear
    drive(1, 2'd3, 8'h02, 0);
    chk("R7", {7'b0, irq_dat}, 8'h00);
    drive(0, 2'd0, 8'd0, 0);
    chk("R7", {7'b0, irq_dat}, 8'h01);
    drive(1, 2'd2, 8'h00, 0);
    chk("R7", {7'b0, irq_dat}, 8'h01);
    drive(0, 2'd0, 8'd0, 0);
    chk("R7", {7'b0, irq_dat}, 8'h00);
    check_all();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule